// File: doc/BRIEF.md
# Grouped-Priority Interrupt Level Controller

This block collects interrupt requests for eight levels, numbered 0 to 7, and decides which one the CPU should take next. A one-cycle pulse on a level's request input latches that level's pending flag. The flag stays set until the CPU acknowledges that same level. A per-level mask, a global enable and a priority register decide whether the CPU interrupt line is raised and which level number is reported on it.

The levels are arbitrated in three unequal groups: group A holds levels 0 and 1, group B holds levels 2 to 4, and group C holds levels 5 to 7. The priority register picks the order of the three groups and the order inside each group.

Software reaches four registers through a small register bus: mask, priority, pending (read-only) and mode. Separate enable and disable strobes set and clear the global enable. The mode register also stores a fast-interrupt enable bit, which the block only drives out. A write to the mask register while interrupts are globally enabled is still carried out, but it sets a sticky error flag.

Top module: `intlvl_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the following are all 0: the mask, priority and pending registers, the global enable, the fast-interrupt bit, the error flag and `cpu_irq_o`.
- R2: A 1 on `req_i[n]` at a clock edge sets pending bit n. The pending register is read at bus address 2, with bit n for level n.
- R3: A pending bit stays set while its level is masked. It is cleared only by `ack_i` with `ack_level_i` equal to its level. If a request for that level arrives in the same cycle as the acknowledge, the bit stays set.
- R4: The global enable is bit 0 of the mode register (address 3). `ei_i` sets it and `di_i` clears it. If both strobes are high, disable wins. Either strobe overrides a bus write to bit 0 in the same cycle.
- R5: `cpu_irq_o` is 1 exactly when the global enable is 1 and some level is both pending and unmasked. Mask bit n = 1 enables level n.
- R6: Priority bits [2:0] set the group order: 0 A>B>C, 1 A>C>B, 2 B>A>C, 3 B>C>A, 4 C>A>B, 5 C>B>A. Codes 6 and 7 behave as code 0.
- R7: Priority bit 3 = 1 puts level 1 before level 0. For group B, bit 5 picks the first level (0: level 2, 1: level 4) and bit 4 swaps the remaining two, which otherwise go in ascending order. Group C uses bits 7 and 6 in the same way over levels 5, 6 and 7.
- R8: `irq_level_o` gives the highest-priority level that is pending and unmasked, independent of the global enable. It is 0 when there is no such level.
- R9: A bus write with `bus_wr_i` updates the register at `bus_addr_i`: 0 mask, 1 priority, 3 mode. Writes to address 2 are ignored. `bus_rdata_o` always shows the register at `bus_addr_i`.
- R10: Mode bit 1 is the fast-interrupt enable. It is written by the bus, driven on `fast_en_o`, and read back in bit 1. Mode bits 7:2 read as 0.
- R11: A mask write while the global enable is 1 still updates the mask. It also sets `mask_err_o`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 8 | Per-level request pulses |
| ack_i | input | 1 | Acknowledge strobe from the CPU |
| ack_level_i | input | 3 | Level being acknowledged |
| ei_i | input | 1 | Global enable strobe |
| di_i | input | 1 | Global disable strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for the current address |
| cpu_irq_o | output | 1 | Interrupt request to the CPU |
| irq_level_o | output | 3 | Winning level number |
| fast_en_o | output | 1 | Stored fast-interrupt enable |
| mask_err_o | output | 1 | Sticky flag for a mask write made while enabled |

## Verification
The assertions take for granted that every strobe is known and lasts one cycle per event. They also assume that the acknowledge property is judged only in cycles where no request for the acknowledged level is present, which the property itself guards.

The random stimulus draws requests, acknowledges to any level, rare enable and disable strobes, and bus writes to all four addresses. Because these are unconstrained, mask writes happen both with the global enable off and with it on, and acknowledges sometimes collide with requests for the same level. Directed sequences before the random phase step through every group-order code and within-group setting.

// File: rtl/intlvl_pkg.sv
// Shared constants and types for the grouped-priority interrupt controller.
// Assumes eight levels in three fixed groups (2, 3 and 3 levels).
package intlvl_pkg;
    localparam int NUM_LVL = 8;
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int NUM_GRP = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        GRP_A = 2'd0,
        GRP_B = 2'd1,
        GRP_C = 2'd2
    } grp_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_MASK = 2'd0,
        RA_PRIO = 2'd1,
        RA_PEND = 2'd2,
        RA_MODE = 2'd3
    } reg_addr_e;

    // Group geometry: size and first level of each group.
    function automatic int grp_size(input int g);
        return (g == 0) ? 2 : 3;
    endfunction

    function automatic int grp_base(input int g);
        return (g == 0) ? 0 : ((g == 1) ? 2 : 5);
    endfunction
endpackage

// File: rtl/intlvl_pending.sv
// Pending flags, one per level.
// Assumes request and acknowledge are single-cycle strobes. A request
// in the same cycle as an acknowledge of the same level keeps the flag set.
module intlvl_pending
    import intlvl_pkg::*;
#(
    parameter int N = NUM_LVL
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         ack,
    input  lvl_t         ack_lvl,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic clr;
        // Decode the acknowledge for this level.
        assign clr = ack && (ack_lvl == lvl_t'(i));
        // Latch the request, drop the flag on acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n) pend[i] <= 1'b0;
            else        pend[i] <= req[i] | (pend[i] & ~clr);
        end
    end
endmodule

// File: rtl/intlvl_regs.sv
// Register file: mask, priority, mode (global enable and fast bit), and the
// sticky mask-write error. Read data is a plain mux on the address.
// Assumes ei/di are single-cycle strobes that take precedence over bus writes.
module intlvl_regs
    import intlvl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ei,
    input  logic              di,
    input  logic [NUM_LVL-1:0] pend,
    output logic [NUM_LVL-1:0] mask,
    output logic [DATA_W-1:0] prio,
    output logic              gie,
    output logic              fast,
    output logic              err,
    output logic [DATA_W-1:0] rdata
);
    logic wr_mask, wr_prio, wr_mode;
    logic unused_wdata_hi;

    assign wr_mask = wr && (addr == RA_MASK);
    assign wr_prio = wr && (addr == RA_PRIO);
    assign wr_mode = wr && (addr == RA_MODE);
    assign unused_wdata_hi = ^wdata[DATA_W-1:2];

    // Mask and priority registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            prio <= '0;
        end else begin
            if (wr_mask) mask <= wdata[NUM_LVL-1:0];
            if (wr_prio) prio <= wdata;
        end
    end

    // Global enable: disable strobe, then enable strobe, then bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)       gie <= 1'b0;
        else if (di)      gie <= 1'b0;
        else if (ei)      gie <= 1'b1;
        else if (wr_mode) gie <= wdata[0];
    end

    // Fast-interrupt enable, stored only.
    always_ff @(posedge clk) begin
        if (!rst_n)       fast <= 1'b0;
        else if (wr_mode) fast <= wdata[1];
    end

    // Sticky error for a mask write while globally enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                err <= 1'b0;
        else if (wr_mask && gie)   err <= 1'b1;
    end

    // Read mux.
    always_comb begin
        unique case (addr)
            RA_MASK: rdata = mask;
            RA_PRIO: rdata = prio;
            RA_PEND: rdata = pend;
            default: rdata = {{(DATA_W-2){1'b0}}, fast, gie};
        endcase
    end
endmodule

// File: rtl/intlvl_grp_arb.sv
// Fixed-size group arbiter for a 2- or 3-level group.
// head_sel=1 puts the highest level of the group first. For N=3,
// tail_swap reverses the two remaining levels. For N=2, tail_swap has no effect.
module intlvl_grp_arb
    import intlvl_pkg::*;
#(
    parameter int N    = 3,
    parameter int BASE = 2
) (
    input  logic [N-1:0] elig,
    input  logic         head_sel,
    input  logic         tail_swap,
    output logic         hit,
    output lvl_t         lvl
);
    logic [2:0] e3;
    logic [1:0] ord [3];
    logic       unused_tail;

    assign e3          = 3'(elig);
    assign unused_tail = tail_swap;

    // Build the in-group order from the two control bits.
    always_comb begin
        if (N == 2) begin
            ord[0] = head_sel ? 2'd1 : 2'd0;
            ord[1] = head_sel ? 2'd0 : 2'd1;
            ord[2] = 2'd0;
        end else if (!head_sel) begin
            ord[0] = 2'd0;
            ord[1] = tail_swap ? 2'd2 : 2'd1;
            ord[2] = tail_swap ? 2'd1 : 2'd2;
        end else begin
            ord[0] = 2'd2;
            ord[1] = tail_swap ? 2'd1 : 2'd0;
            ord[2] = tail_swap ? 2'd0 : 2'd1;
        end
    end

    // Pick the first eligible level in order (scan from the back).
    always_comb begin
        hit = 1'b0;
        lvl = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (e3[ord[i]]) begin
                hit = 1'b1;
                lvl = lvl_t'(BASE) + lvl_t'(ord[i]);
            end
        end
    end
endmodule

// File: rtl/intlvl_arbiter.sv
// Two-stage priority resolver: one arbiter per group, then a group-order
// selector driven by priority bits [2:0]. Output level is 0 when nothing wins.
module intlvl_arbiter
    import intlvl_pkg::*;
(
    input  logic [NUM_LVL-1:0] elig,
    input  logic [DATA_W-1:0]  prio,
    output logic               hit,
    output lvl_t               lvl
);
    logic       g_head [NUM_GRP];
    logic       g_swap [NUM_GRP];
    logic       g_hit  [NUM_GRP];
    lvl_t       g_lvl  [NUM_GRP];
    grp_e       go     [NUM_GRP];

    // Route the in-group control bits.
    always_comb begin
        g_head[0] = prio[3];
        g_swap[0] = 1'b0;
        g_head[1] = prio[5];
        g_swap[1] = prio[4];
        g_head[2] = prio[7];
        g_swap[2] = prio[6];
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int GN = grp_size(g);
        localparam int GB = grp_base(g);
        intlvl_grp_arb #(.N(GN), .BASE(GB)) i_grp (
            .elig      (elig[GB +: GN]),
            .head_sel  (g_head[g]),
            .tail_swap (g_swap[g]),
            .hit       (g_hit[g]),
            .lvl       (g_lvl[g])
        );
    end

    // Decode the group order code.
    always_comb begin
        case (prio[2:0])
            3'd1:    begin go[0] = GRP_A; go[1] = GRP_C; go[2] = GRP_B; end
            3'd2:    begin go[0] = GRP_B; go[1] = GRP_A; go[2] = GRP_C; end
            3'd3:    begin go[0] = GRP_B; go[1] = GRP_C; go[2] = GRP_A; end
            3'd4:    begin go[0] = GRP_C; go[1] = GRP_A; go[2] = GRP_B; end
            3'd5:    begin go[0] = GRP_C; go[1] = GRP_B; go[2] = GRP_A; end
            default: begin go[0] = GRP_A; go[1] = GRP_B; go[2] = GRP_C; end
        endcase
    end

    // Take the first group in order that has a winner.
    always_comb begin
        hit = 1'b0;
        lvl = '0;
        for (int i = NUM_GRP - 1; i >= 0; i--) begin
            if (g_hit[go[i]]) begin
                hit = 1'b1;
                lvl = g_lvl[go[i]];
            end
        end
    end
endmodule

// File: rtl/intlvl_ctrl.sv
// Top of the grouped-priority interrupt level controller.
// Assumes one clock domain, synchronous active-low reset and single-cycle
// strobes on req_i, ack_i, ei_i, di_i and bus_wr_i.
module intlvl_ctrl
    import intlvl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        req_i,
    input  logic              ack_i,
    input  logic [2:0]        ack_level_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              bus_wr_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic              cpu_irq_o,
    output logic [2:0]        irq_level_o,
    output logic              fast_en_o,
    output logic              mask_err_o
);
    logic [NUM_LVL-1:0] pend_q;
    logic [NUM_LVL-1:0] mask_q;
    logic [DATA_W-1:0]  prio_q;
    logic               gie;
    logic               win_hit;
    lvl_t               win_lvl;

    intlvl_pending #(.N(NUM_LVL)) i_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_i),
        .ack     (ack_i),
        .ack_lvl (ack_level_i),
        .pend    (pend_q)
    );

    intlvl_regs i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr_i),
        .addr  (bus_addr_i),
        .wdata (bus_wdata_i),
        .ei    (ei_i),
        .di    (di_i),
        .pend  (pend_q),
        .mask  (mask_q),
        .prio  (prio_q),
        .gie   (gie),
        .fast  (fast_en_o),
        .err   (mask_err_o),
        .rdata (bus_rdata_o)
    );

    intlvl_arbiter i_arb (
        .elig (pend_q & mask_q),
        .prio (prio_q),
        .hit  (win_hit),
        .lvl  (win_lvl)
    );

    // CPU request gated by the global enable.
    assign cpu_irq_o   = gie & win_hit;
    assign irq_level_o = win_lvl;
endmodule

// File: rtl/intlvl_ctrl_chk.sv
// Property checker for intlvl_ctrl, attached by bind.
// Assumes known, single-cycle strobes at the top-level inputs.
module intlvl_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] req_i,
    input logic       ack_i,
    input logic [2:0] ack_level_i,
    input logic       ei_i,
    input logic       di_i,
    input logic       cpu_irq_o,
    input logic [2:0] irq_level_o,
    input logic       mask_err_o,
    input logic [7:0] pend_q,
    input logic [7:0] mask_q,
    input logic       gie
);
    AST_REQ_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i != 8'd0) |=> ((pend_q & $past(req_i)) == $past(req_i))); // R2

    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R3

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !req_i[ack_level_i]) |=> !pend_q[$past(ack_level_i)]); // R3

    AST_DI_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        di_i |=> !gie); // R4

    AST_EI_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (ei_i && !di_i) |=> gie); // R4

    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq_o |-> gie); // R5

    AST_LEVEL_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq_o |-> (pend_q[irq_level_o] && mask_q[irq_level_o])); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mask_err_o |=> mask_err_o); // R11
endmodule

bind intlvl_ctrl intlvl_ctrl_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .ack_i       (ack_i),
    .ack_level_i (ack_level_i),
    .ei_i        (ei_i),
    .di_i        (di_i),
    .cpu_irq_o   (cpu_irq_o),
    .irq_level_o (irq_level_o),
    .mask_err_o  (mask_err_o),
    .pend_q      (pend_q),
    .mask_q      (mask_q),
    .gie         (gie)
);

// File: tb/test_intlvl_ctrl.sv
module test_intlvl_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req_i;
    logic       ack_i;
    logic [2:0] ack_level_i;
    logic       ei_i, di_i, bus_wr_i;
    logic [1:0] bus_addr_i;
    logic [7:0] bus_wdata_i;
    logic [7:0] bus_rdata_o;
    logic       cpu_irq_o;
    logic [2:0] irq_level_o;
    logic       fast_en_o, mask_err_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model state
    logic [7:0] m_mask, m_prio, m_pend;
    logic       m_gie, m_fast, m_err;

    always #5 clk = ~clk;

    intlvl_ctrl i_intlvl_ctrl (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int rank_of(input logic [7:0] p, input int l);
        int pos_tbl [6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{2,0,1}, '{1,2,0}, '{2,1,0}};
        int code, g, k, w;
        code = (p[2:0] > 3'd5) ? 0 : int'(p[2:0]);
        g = (l < 2) ? 0 : ((l < 5) ? 1 : 2);
        if (g == 0) w = (l == 0) ? int'(p[3]) : int'(!p[3]);
        else begin
            logic h, s;
            k = (g == 1) ? l - 2 : l - 5;
            h = (g == 1) ? p[5] : p[7];
            s = (g == 1) ? p[4] : p[6];
            if (!h) w = (k == 0) ? 0 : ((k == 1) ? (s ? 2 : 1) : (s ? 1 : 2));
            else    w = (k == 2) ? 0 : ((k == 0) ? (s ? 2 : 1) : (s ? 1 : 2));
        end
        return pos_tbl[code][g] * 3 + w;
    endfunction

    function automatic int exp_level();
        int best = 0, best_r = 99;
        for (int l = 0; l < 8; l++)
            if (m_pend[l] && m_mask[l] && rank_of(m_prio, l) < best_r) begin
                best = l;
                best_r = rank_of(m_prio, l);
            end
        return best;
    endfunction

    function automatic int exp_read(input logic [1:0] a);
        case (a)
            2'd0: return int'(m_mask);
            2'd1: return int'(m_prio);
            2'd2: return int'(m_pend);
            default: return int'({6'd0, m_fast, m_gie});
        endcase
    endfunction

    // One cycle: drive, compare with model before the edge, advance model.
    task automatic step(input logic [7:0] rq, input logic ak, input logic [2:0] al,
                        input logic e, input logic d, input logic w,
                        input logic [1:0] a, input logic [7:0] wd);
        string rtag;
        @(negedge clk);
        req_i = rq; ack_i = ak; ack_level_i = al; ei_i = e; di_i = d;
        bus_wr_i = w; bus_addr_i = a; bus_wdata_i = wd;
        #1;
        rtag = (a == 2'd2) ? "R2 pending read" : ((a == 2'd3) ? "R4 mode read" : "R9 reg read");
        chk(rtag, int'(bus_rdata_o), exp_read(a));
        chk("R5 cpu_irq", int'(cpu_irq_o), int'(m_gie && ((m_pend & m_mask) != 0)));
        chk("R8 level", int'(irq_level_o), exp_level());
        chk("R10 fast", int'(fast_en_o), int'(m_fast));
        chk("R11 err", int'(mask_err_o), int'(m_err));
        // model update
        m_pend = rq | (m_pend & ~(ak ? (8'd1 << al) : 8'd0));
        if (w && a == 2'd0) begin
            if (m_gie) m_err = 1'b1;
            m_mask = wd;
        end
        if (w && a == 2'd1) m_prio = wd;
        if (w && a == 2'd3) m_fast = wd[1];
        if (d)                      m_gie = 1'b0;
        else if (e)                 m_gie = 1'b1;
        else if (w && a == 2'd3)    m_gie = wd[0];
    endtask

    task automatic idle(input logic [1:0] a);
        step(8'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, a, 8'd0);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        step(8'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, a, d);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req_i = '0; ack_i = 0; ack_level_i = '0; ei_i = 0; di_i = 0;
        bus_wr_i = 0; bus_addr_i = '0; bus_wdata_i = '0;
        m_mask = '0; m_prio = '0; m_pend = '0; m_gie = 0; m_fast = 0; m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on every register and output
        for (int a = 0; a < 4; a++) begin
            bus_addr_i = 2'(a);
            #1;
            chk("R1 reset reg", int'(bus_rdata_o), 0);
        end
        chk("R1 reset irq", int'(cpu_irq_o), 0);
        chk("R1 reset err", int'(mask_err_o), 0);

        // R2/R3: latch while masked, ack+req collision keeps flag
        step(8'h21, 1'b0, 3'd0, 0, 0, 0, 2'd2, 8'd0);
        idle(2'd2); idle(2'd2);
        chk("R3 held masked", int'(bus_rdata_o), 'h21);
        step(8'h20, 1'b1, 3'd5, 0, 0, 0, 2'd2, 8'd0);
        idle(2'd2);
        chk("R3 ack+req keeps", int'(bus_rdata_o[5]), 1);
        step(8'h00, 1'b1, 3'd5, 0, 0, 0, 2'd2, 8'd0);
        idle(2'd2);
        chk("R3 ack clears", int'(bus_rdata_o), 'h01);
        // R9: pending register ignores writes
        wreg(2'd2, 8'hFE);
        idle(2'd2);
        chk("R9 pend read-only", int'(bus_rdata_o), 'h01);

        // R5: mask write while disabled, then enable
        wreg(2'd0, 8'hFF);
        idle(2'd0);
        chk("R5 irq off w/o gie", int'(cpu_irq_o), 0);
        chk("R11 no err when disabled", int'(mask_err_o), 0);
        step(8'd0, 0, 3'd0, 1'b1, 1'b0, 0, 2'd3, 8'd0);
        idle(2'd3);
        chk("R4 ei sets", int'(bus_rdata_o), 1);
        chk("R5 irq on", int'(cpu_irq_o), 1);
        // R4: both strobes -> disable wins, strobe beats bus write
        step(8'd0, 0, 3'd0, 1'b1, 1'b1, 0, 2'd3, 8'd0);
        idle(2'd3);
        chk("R4 di wins", int'(bus_rdata_o[0]), 0);
        step(8'd0, 0, 3'd0, 1'b1, 1'b0, 1'b1, 2'd3, 8'h00);
        idle(2'd3);
        chk("R4 ei beats write", int'(bus_rdata_o[0]), 1);

        // R11: mask write while enabled
        wreg(2'd0, 8'hF7);
        idle(2'd0);
        chk("R11 mask updated", int'(bus_rdata_o), 'hF7);
        chk("R11 err set", int'(mask_err_o), 1);

        // R6: group orders with levels 0, 2 and 5 pending
        step(8'h25, 0, 3'd0, 0, 0, 0, 2'd0, 8'd0);
        for (int c = 0; c < 8; c++) begin
            wreg(2'd1, 8'(c));
            idle(2'd1);
            chk("R6 group order", int'(irq_level_o), exp_level());
        end
        // R7: within-group orders, only group B and C pending
        step(8'hFC, 1'b1, 3'd0, 0, 0, 0, 2'd2, 8'd0);
        for (int v = 0; v < 16; v++) begin
            wreg(2'd1, {v[1:0], v[3:2], 4'b0011});
            idle(2'd1);
            chk("R7 in-group order", int'(irq_level_o), exp_level());
        end
        step(8'h03, 0, 3'd0, 0, 0, 0, 2'd0, 8'd0);
        wreg(2'd1, 8'h08);
        idle(2'd1);
        chk("R7 group A swap", int'(irq_level_o), 1);

        // R10: fast-interrupt bit
        wreg(2'd3, 8'hFE);
        idle(2'd3);
        chk("R10 fast out", int'(fast_en_o), 1);
        chk("R10 mode read", int'(bus_rdata_o), 'h02);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] rq;
            int r;
            r = $urandom % 8;
            rq = (r < 3) ? 8'($urandom) & 8'($urandom) : 8'd0;
            step(rq, ($urandom % 3) == 0, 3'($urandom), ($urandom % 16) == 0,
                 ($urandom % 16) == 0, ($urandom % 4) == 0, 2'($urandom), 8'($urandom));
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule